// File: doc/BRIEF.md
# Asynchronous Configuration Write Port

This block is the host-facing load path of a filter engine. A host drives a 10-bit data word and a 9-bit address, then raises a write strobe. The strobe's rising edge captures both, with no relation to the processing clock. The block carries each captured write into the processing clock domain and acts on it there exactly once.

Two addresses at the bottom of the map hold configuration words, which the block keeps and drives as outputs. The upper half of the map, where the top address bit is set, is coefficient storage. A write there is passed out as a one-cycle write pulse, together with a set index, a tap index and the data, to a coefficient memory outside the block.

A configuration write also starts a timed local reset for the datapath. That reset never touches coefficient writes. The registers can still be written while it runs, and each new configuration write restarts its count. Every other address is ignored.

Top module: `cfg_host_port`

## Requirements
- R1: After `rst_n` is released, both configuration words read 0, `dp_rst` is 0 and `coef_we` is 0.
- R2: A write to address 0x000 loads `cfg_word_a`, and a write to 0x001 loads `cfg_word_b`. The new value is visible after the third rising clock edge that follows the strobe's rising edge. The value is kept until that word is written again, and `dp_rst` does not clear it.
- R3: A write to either configuration address raises `dp_rst` in the same cycle the register takes its value. `dp_rst` then stays high for exactly 6 clock cycles.
- R4: A write to an address with bit 8 set produces `coef_we` high for exactly one cycle, in the same cycle a configuration write would update. In that cycle `coef_set` equals address bits 7:3, `coef_tap` equals bits 2:0 and `coef_data` equals the data word.
- R5: A coefficient write never raises `dp_rst`. A coefficient write issued while `dp_rst` is high still produces its `coef_we` pulse.
- R6: A configuration write made while `dp_rst` is high loads the new value and restarts the count. `dp_rst` then stays high for 6 cycles counted from that second update.
- R7: Writes to addresses 0x002 through 0x0FF change neither configuration word. They raise neither `dp_rst` nor `coef_we`.
- R8: Each strobe rising edge is acted on exactly once. The result is a single update or a single `coef_we` pulse, never a repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_stb | input | 1 | Host write strobe, captures on its rising edge |
| wr_addr | input | 9 | Host write address |
| wr_data | input | 10 | Host write data |
| cfg_word_a | output | 10 | Configuration word at address 0x000 |
| cfg_word_b | output | 10 | Configuration word at address 0x001 |
| coef_we | output | 1 | One-cycle coefficient write pulse |
| coef_set | output | 5 | Coefficient set index for the pulse |
| coef_tap | output | 3 | Coefficient tap index for the pulse |
| coef_data | output | 10 | Coefficient value for the pulse |
| dp_rst | output | 1 | Timed datapath reset, active high |

## Verification
A stuck or doubled crossing shows at the ports within four clocks of a strobe. It appears as a missing or repeated `coef_we` pulse, or as a configuration word that never updates. A wrong address decode shows in the cycle of the update: the wrong register changes, or a reset or pulse fires for an ignored address. A timer that miscounts or fails to reload changes the length of `dp_rst`. A second write during the reset window exposes this within at most six cycles.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CFGA = 2'd1,
    HIT_CFGB = 2'd2,
    HIT_COEF = 2'd3
  } hit_e;

  // Top address bit selects coefficient space; below it, only 0 and 1 are mapped.
  function automatic hit_e classify_addr(input int unsigned addr, input int unsigned addr_w);
    int unsigned top;
    int unsigned low;
    top = (addr >> (addr_w - 1)) & 1;
    low = addr & ((1 << (addr_w - 1)) - 1);
    if (top != 0)      return HIT_COEF;
    else if (low == 0) return HIT_CFGA;
    else if (low == 1) return HIT_CFGB;
    else               return HIT_NONE;
  endfunction

  // Next value of the reset countdown: a start reloads, otherwise count down to zero.
  function automatic int unsigned timer_next(input int unsigned cur, input logic start,
                                             input int unsigned limit);
    if (start)         return limit;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/wr_capture.sv
module wr_capture #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 10
) (
  input  logic              wr_stb,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_tgl
);
  // Strobe-domain holding registers; the toggle marks one new write per edge.
  always_ff @(posedge wr_stb or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_tgl  <= 1'b0;
    end else begin
      cap_addr <= wr_addr;
      cap_data <= wr_data;
      cap_tgl  <= ~cap_tgl;
    end
  end
endmodule

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic evt_pulse
);
  logic [STAGES-1:0] sreg;
  logic              seen;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sreg[0] <= 1'b0;
          else        sreg[0] <= tgl_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sreg[g] <= 1'b0;
          else        sreg[g] <= sreg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= sreg[STAGES-1];
  end

  assign evt_pulse = sreg[STAGES-1] ^ seen;

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 10,
  parameter int SET_W  = 5,
  parameter int TAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] cfg_a,
  output logic [DATA_W-1:0] cfg_b,
  output logic              coef_we,
  output logic [SET_W-1:0]  coef_set,
  output logic [TAP_W-1:0]  coef_tap,
  output logic [DATA_W-1:0] coef_data,
  output logic              cfg_hit
);
  hit_e kind;
  logic coef_hit;

  assign kind     = classify_addr(int'(cap_addr), ADDR_W);
  assign cfg_hit  = evt && (kind == HIT_CFGA || kind == HIT_CFGB);
  assign coef_hit = evt && (kind == HIT_COEF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a <= '0;
      cfg_b <= '0;
    end else if (evt) begin
      if (kind == HIT_CFGA) cfg_a <= cap_data;
      if (kind == HIT_CFGB) cfg_b <= cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_we   <= 1'b0;
      coef_set  <= '0;
      coef_tap  <= '0;
      coef_data <= '0;
    end else begin
      coef_we <= coef_hit;
      if (coef_hit) begin
        coef_set  <= cap_addr[TAP_W +: SET_W];
        coef_tap  <= cap_addr[TAP_W-1:0];
        coef_data <= cap_data;
      end
    end
  end

  // R2
  cfga_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && kind == HIT_CFGA) |=> (cfg_a == $past(cap_data)));
  // R7
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && kind == HIT_NONE) |=> ($stable(cfg_a) && $stable(cfg_b) && !coef_we));
  // R4
  coef_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> !coef_we);
  // R8
  coef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_hit |=> !coef_we);
endmodule

// File: rtl/rst_timer.sv
module rst_timer
  import cfg_port_pkg::*;
#(
  parameter int RST_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic dp_rst
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(timer_next(int'(cnt), start, RST_CYCLES));
  end

  assign dp_rst = (cnt != '0);

  // R3
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> dp_rst);
  // R3
  rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_rst) |-> ($past(cnt) == CNT_W'(1) && !$past(start)));
endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 10,
  parameter int SET_W       = 5,
  parameter int TAP_W       = 3,
  parameter int RST_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cfg_word_a,
  output logic [DATA_W-1:0] cfg_word_b,
  output logic              coef_we,
  output logic [SET_W-1:0]  coef_set,
  output logic [TAP_W-1:0]  coef_tap,
  output logic [DATA_W-1:0] coef_data,
  output logic              dp_rst
);
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              cap_tgl;
  logic              wr_evt;
  logic              cfg_hit;

  wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .wr_stb(wr_stb), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_tgl(cap_tgl)
  );

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(cap_tgl), .evt_pulse(wr_evt)
  );

  reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .TAP_W(TAP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt(wr_evt), .cap_addr(cap_addr), .cap_data(cap_data),
    .cfg_a(cfg_word_a), .cfg_b(cfg_word_b), .coef_we(coef_we), .coef_set(coef_set),
    .coef_tap(coef_tap), .coef_data(coef_data), .cfg_hit(cfg_hit)
  );

  rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cfg_hit), .dp_rst(dp_rst)
  );

  // R5
  coef_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we && !$past(dp_rst) && !$past(cfg_hit)) |-> !dp_rst);
endmodule

// File: tb/test_cfg_host_port.sv
module test_cfg_host_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [9:0] cfg_word_a, cfg_word_b, coef_data;
  logic       coef_we, dp_rst;
  logic [4:0] coef_set;
  logic [2:0] coef_tap;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cfg_host_port i_cfg_host_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_word_a(cfg_word_a), .cfg_word_b(cfg_word_b), .coef_we(coef_we),
    .coef_set(coef_set), .coef_tap(coef_tap), .coef_data(coef_data), .dp_rst(dp_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe rises at a falling clock edge; returns just after the following falling edge.
  task automatic host_write(input logic [8:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_stb  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // After host_write, two more rising edges reach the update cycle; sample just after it.
  task automatic to_update();
    repeat (2) @(posedge clk);
    #1;
  endtask

  // Counts dp_rst high cycles, starting from the current (already sampled) cycle.
  task automatic count_rst(output int n);
    n = 0;
    while (dp_rst && n < 40) begin
      n++;
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    check("R1 cfg_word_a", cfg_word_a, 0);
    check("R1 cfg_word_b", cfg_word_b, 0);
    check("R1 dp_rst", dp_rst, 0);
    check("R1 coef_we", coef_we, 0);
  endtask

  task automatic t_cfg(input logic [8:0] a, input logic [9:0] d);
    int n;
    logic [9:0] other;
    other = (a == 9'h000) ? cfg_word_b : cfg_word_a;
    host_write(a, d);
    to_update();
    check("R2 word loaded", (a == 9'h000) ? cfg_word_a : cfg_word_b, d);
    check("R2 other word kept", (a == 9'h000) ? cfg_word_b : cfg_word_a, other);
    check("R3 dp_rst rises with update", dp_rst, 1);
    count_rst(n);
    check("R3 dp_rst length", n, 6);
    check("R2 word survives dp_rst", (a == 9'h000) ? cfg_word_a : cfg_word_b, d);
  endtask

  task automatic t_coef(input logic [4:0] s, input logic [2:0] t, input logic [9:0] d);
    host_write({1'b1, s, t}, d);
    to_update();
    check("R4 coef_we pulse", coef_we, 1);
    check("R4 coef_set", coef_set, s);
    check("R4 coef_tap", coef_tap, t);
    check("R4 coef_data", coef_data, d);
    check("R5 no dp_rst on coef write", dp_rst, 0);
    @(posedge clk); #1;
    check("R8 coef_we single cycle", coef_we, 0);
    repeat (4) @(posedge clk);
    #1;
    check("R8 no repeat pulse", coef_we, 0);
  endtask

  task automatic t_unmapped(input logic [8:0] a);
    logic [9:0] ea, eb;
    int hits;
    ea = cfg_word_a;
    eb = cfg_word_b;
    hits = 0;
    host_write(a, 10'h3FF);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (dp_rst || coef_we) hits++;
    end
    check("R7 no reset or pulse", hits, 0);
    check("R7 cfg_word_a unchanged", cfg_word_a, ea);
    check("R7 cfg_word_b unchanged", cfg_word_b, eb);
  endtask

  task automatic t_restart();
    int n;
    host_write(9'h000, 10'h111);
    to_update();
    check("R6 first value", cfg_word_a, 10'h111);
    host_write(9'h000, 10'h222);
    to_update();
    check("R6 second value during reset", cfg_word_a, 10'h222);
    count_rst(n);
    check("R6 count restarted", n, 6);
  endtask

  task automatic t_coef_in_rst();
    int n;
    host_write(9'h001, 10'h0C3);
    to_update();
    check("R3 dp_rst high", dp_rst, 1);
    host_write({1'b1, 5'd9, 3'd6}, 10'h155);
    to_update();
    check("R5 coef_we during dp_rst", coef_we, 1);
    check("R5 coef_set during dp_rst", coef_set, 5'd9);
    check("R5 coef_data during dp_rst", coef_data, 10'h155);
    count_rst(n);
    check("R5 coef write did not extend dp_rst", n, 3);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_cfg(9'h000, 10'h2A5);
    t_cfg(9'h001, 10'h15A);
    t_coef(5'd0, 3'd0, 10'h001);
    t_coef(5'd31, 3'd7, 10'h3FF);
    t_coef(5'd18, 3'd3, 10'h0AB);
    t_unmapped(9'h002);
    t_unmapped(9'h0FF);
    t_unmapped(9'h081);
    t_restart();
    t_coef_in_rst();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule